// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with HI/LO Result Pair

This block carries out integer multiply and divide for a small RISC core. It owns the two result registers, HI and LO. A command is offered with `cmdValid` together with a 3-bit operation code and two operands, and it is taken on any clock edge where `cmdReady` is high. Multiply and divide then iterate one bit per cycle on operand magnitudes. A final cycle applies the sign correction and writes HI and LO. `busy` is high for the whole of that time.

Two move commands load HI or LO straight from operand A in the cycle the command is taken. The core reads HI or LO through a read port. If a read is requested while an operation is in flight, `rdStall` holds it off until the operation ends. A divide whose divisor is zero is taken but does nothing: both result registers keep their previous contents.

Top module: `mdu_hilo`

## Requirements
- R1: Op code 0 (signed multiply) treats both operands as two's complement and forms the full 2W-bit product; its upper W bits go to HI and its lower W bits go to LO.
- R2: Op code 1 (unsigned multiply) treats both operands as unsigned and splits the 2W-bit product across HI (upper half) and LO (lower half).
- R3: Op code 3 (unsigned divide) with a nonzero divisor writes the quotient cmdA/cmdB to LO and the remainder to HI.
- R4: Op code 2 (signed divide) with a nonzero divisor truncates toward zero, so the remainder in HI has the sign of the dividend. The most negative value divided by minus one gives quotient 0x80000000 and remainder 0.
- R5: A divide (op code 2 or 3) with cmdB equal to zero is accepted, leaves HI and LO unchanged, and never raises `busy`.
- R6: Op code 4 loads cmdA into HI and op code 5 loads cmdA into LO, each on the accepting edge. The other register is unchanged and `busy` stays low.
- R7: After a multiply or divide is accepted, `busy` is high for exactly W+1 cycles, starting from the cycle after acceptance. The new HI/LO values are readable in the first cycle in which `busy` is low again.
- R8: While an operation runs, HI and LO keep their previous values.
- R9: `cmdReady` is low while `busy` is high, and a command offered during that time has no effect.
- R10: `rdData` shows HI when `rdSel` is 1 and LO when it is 0. `rdStall` is high exactly when `rdReq` is high during `busy`.
- R11: After reset HI and LO are zero, `busy` is low and `cmdReady` is high.
- R12: Op codes 6 and 7 are accepted and change neither HI, LO nor `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit can take a command this cycle |
| cmdOp | input | 3 | Operation code (0 mul signed, 1 mul unsigned, 2 div signed, 3 div unsigned, 4 load HI, 5 load LO) |
| cmdA | input | W | Operand A: multiplicand, dividend or move value |
| cmdB | input | W | Operand B: multiplier or divisor |
| rdReq | input | 1 | Read of HI or LO requested |
| rdSel | input | 1 | Read select: 1 for HI, 0 for LO |
| rdData | output | W | Selected result register |
| rdStall | output | 1 | Read must wait for the running operation |
| busy | output | 1 | Multiply or divide in progress |

## Verification
A 4-bit instance is swept over every operand pair for all four arithmetic codes. Against a simple arithmetic model, that sweep exposes any slip in sign handling, in the carry of the shift-add step, or in the restoring comparison. Zero divisors in the sweep check that the previous result survives. A design that wrote a partial quotient or a zero there would show a mismatch against the value left by the operation before.

The full-width instance checks the cases that only show up at 32 bits: the most negative value divided by minus one, and signed products that reach the top bit of HI. It also checks negative dividends with positive divisors and the reverse, to pin down truncation. In the same run it measures the busy length, shows that a move offered mid-operation is refused and lost, and shows that reads stall and see only the old HI/LO until the result lands.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam logic [2:0] OP_MULS  = 3'd0;
  localparam logic [2:0] OP_MULU  = 3'd1;
  localparam logic [2:0] OP_DIVS  = 3'd2;
  localparam logic [2:0] OP_DIVU  = 3'd3;
  localparam logic [2:0] OP_SETHI = 3'd4;
  localparam logic [2:0] OP_SETLO = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mduState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch operand magnitudes and sign flags
    logic step;      // one iteration
    logic finish;    // sign fix-up and HI/LO write
    logic wrHi;      // direct move into HI
    logic wrLo;      // direct move into LO
    logic isDiv;     // running operation is a divide
    logic signedOp;  // valid together with load
  } mduCtl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       divZero,
  output logic       cmdReady,
  output logic       busy,
  output mduCtl_t    ctl
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mduState_t    state;
  logic [CW-1:0] cnt;
  logic          divReg;
  logic          idle, accept, isMul, isDivOp, start;

  always_comb begin
    idle    = (state == ST_IDLE);
    accept  = cmdValid && idle;
    isMul   = (cmdOp == OP_MULS) || (cmdOp == OP_MULU);
    isDivOp = (cmdOp == OP_DIVS) || (cmdOp == OP_DIVU);
    start   = accept && (isMul || (isDivOp && !divZero));

    ctl          = '0;
    ctl.load     = start;
    ctl.signedOp = (cmdOp == OP_MULS) || (cmdOp == OP_DIVS);
    ctl.wrHi     = accept && (cmdOp == OP_SETHI);
    ctl.wrLo     = accept && (cmdOp == OP_SETLO);
    ctl.step     = (state == ST_RUN);
    ctl.finish   = (state == ST_FIX);
    ctl.isDiv    = divReg;

    cmdReady = idle;
    busy     = !idle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      divReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          cnt    <= CW'(W - 1);
          divReg <= isDivOp;
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIX;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step, ctl.finish, ctl.wrHi, ctl.wrLo}));  // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step || ctl.finish) |-> !(ctl.load || ctl.wrHi || ctl.wrLo)); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !busy);                                              // R7

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mduCtl_t      ctl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiQ,
  output logic [W-1:0] loQ
);

  localparam int PW = 2 * W;

  logic [W-1:0]  accHi, accLo, opnd;
  logic          negRes, negRem;
  logic          negA, negB;
  logic [W-1:0]  magA, magB;
  logic [W:0]    mulSum;
  logic [W+1:0]  divDiff;
  logic          divOk;
  logic [PW-1:0] prod, prodFix;

  always_comb begin
    negA    = ctl.signedOp && opA[W-1];
    negB    = ctl.signedOp && opB[W-1];
    magA    = negA ? (~opA + 1'b1) : opA;
    magB    = negB ? (~opB + 1'b1) : opB;
    mulSum  = {1'b0, accHi} + {1'b0, (accLo[0] ? opnd : {W{1'b0}})};
    divDiff = {1'b0, accHi, accLo[W-1]} - {2'b00, opnd};
    divOk   = !divDiff[W+1];
    prod    = {accHi, accLo};
    prodFix = negRes ? (~prod + 1'b1) : prod;
  end

  // iteration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi  <= '0;
      accLo  <= '0;
      opnd   <= '0;
      negRes <= 1'b0;
      negRem <= 1'b0;
    end else if (ctl.load) begin
      accHi  <= '0;
      accLo  <= magA;
      opnd   <= magB;
      negRes <= negA ^ negB;
      negRem <= negA;
    end else if (ctl.step) begin
      if (ctl.isDiv) begin
        accHi <= divOk ? divDiff[W-1:0] : {accHi[W-2:0], accLo[W-1]};
        accLo <= {accLo[W-2:0], divOk};
      end else begin
        {accHi, accLo} <= {mulSum, accLo[W-1:1]};
      end
    end
  end

  // architectural result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (ctl.finish) begin
      if (ctl.isDiv) begin
        loQ <= negRes ? (~accLo + 1'b1) : accLo;
        hiQ <= negRem ? (~accHi + 1'b1) : accHi;
      end else begin
        hiQ <= prodFix[PW-1:W];
        loQ <= prodFix[W-1:0];
      end
    end else begin
      if (ctl.wrHi) hiQ <= opA;
      if (ctl.wrLo) loQ <= opA;
    end
  end

  AST_HOLD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ($stable(hiQ) && $stable(loQ)));                    // R8
  AST_MOVE_HI: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrHi |=> (hiQ == $past(opA) && $stable(loQ)));               // R6
  AST_MOVE_LO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrLo |=> (loQ == $past(opA) && $stable(hiQ)));               // R6

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  output logic         cmdReady,
  input  logic [2:0]   cmdOp,
  input  logic [W-1:0] cmdA,
  input  logic [W-1:0] cmdB,
  input  logic         rdReq,
  input  logic         rdSel,
  output logic [W-1:0] rdData,
  output logic         rdStall,
  output logic         busy
);

  mduCtl_t      ctl;
  logic [W-1:0] hiQ, loQ;
  logic         divZero;

  assign divZero = (cmdB == '0);

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .divZero(divZero), .cmdReady(cmdReady), .busy(busy), .ctl(ctl)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(cmdA), .opB(cmdB),
    .hiQ(hiQ), .loQ(loQ)
  );

  assign rdData  = rdSel ? hiQ : loQ;
  assign rdStall = rdReq && busy;

  AST_DIVZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp == OP_DIVS || cmdOp == OP_DIVU) && divZero)
      |=> ($stable(hiQ) && $stable(loQ) && !busy));                  // R5
  AST_ARITH_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp == OP_MULS || cmdOp == OP_MULU)) |=> busy); // R7

endmodule

// File: tb/mdu_hilo_tb.sv
module mdu_hilo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  // full-width instance
  logic        vB = 0, rqB = 0, slB = 0;
  logic [2:0]  opB_ = 0;
  logic [31:0] aB = 0, bB = 0, dB;
  logic        rdyB, stB, bzB;

  mdu_hilo #(.W(32)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(vB), .cmdReady(rdyB), .cmdOp(opB_),
    .cmdA(aB), .cmdB(bB), .rdReq(rqB), .rdSel(slB), .rdData(dB),
    .rdStall(stB), .busy(bzB)
  );

  // small instance for exhaustive sweep
  logic          vS = 0;
  logic [2:0]    opS = 0;
  logic [SW-1:0] aS = 0, bS = 0, dS;
  logic          slS = 0, rdyS, stS, bzS;

  mdu_hilo #(.W(SW)) u_dutSmall (
    .clk(clk), .rstN(rstN), .cmdValid(vS), .cmdReady(rdyS), .cmdOp(opS),
    .cmdA(aS), .cmdB(bS), .rdReq(1'b0), .rdSel(slS), .rdData(dS),
    .rdStall(stS), .busy(bzS)
  );

  logic [31:0]   expHi = 0, expLo = 0;
  logic [SW-1:0] expHiS = 0, expLoS = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      3'd0: begin p = 64'(sa * sb); expHi = p[63:32]; expLo = p[31:0]; end
      3'd1: begin p = {32'd0, a} * {32'd0, b}; expHi = p[63:32]; expLo = p[31:0]; end
      3'd2: if (b != 0) begin expLo = 32'(sa / sb); expHi = 32'(sa % sb); end
      3'd3: if (b != 0) begin expLo = a / b; expHi = a % b; end
      3'd4: expHi = a;
      3'd5: expLo = a;
      default: ;
    endcase
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output int busyCyc);
    @(negedge clk);
    vB = 1; opB_ = op; aB = a; bB = b;
    @(posedge clk);
    @(negedge clk);
    vB = 0;
    busyCyc = 0;
    while (bzB) begin busyCyc++; @(negedge clk); end
    model32(op, a, b);
  endtask

  task automatic read32(input string req);
    slB = 1; #1; check(req, {32'd0, dB}, {32'd0, expHi});
    slB = 0; #1; check(req, {32'd0, dB}, {32'd0, expLo});
  endtask

  task automatic runSmall(input logic [2:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b);
    int sa, sb, ua, ub, p;
    @(negedge clk);
    vS = 1; opS = op; aS = a; bS = b;
    @(posedge clk);
    @(negedge clk);
    vS = 0;
    while (bzS) @(negedge clk);
    sa = int'($signed(a)); sb = int'($signed(b));
    ua = int'(a); ub = int'(b);
    case (op)
      3'd0: begin p = sa * sb; {expHiS, expLoS} = (2*SW)'(p); end
      3'd1: begin p = ua * ub; {expHiS, expLoS} = (2*SW)'(p); end
      3'd2: if (b != 0) begin expLoS = SW'(sa / sb); expHiS = SW'(sa % sb); end
      3'd3: if (b != 0) begin expLoS = SW'(ua / ub); expHiS = SW'(ua % ub); end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R7: actual hung run expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin : stim
    int bc;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check("R11", {62'd0, bzB, rdyB}, 64'd1);
    read32("R11");

    // R1 signed multiply
    run32(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, bc); read32("R1");
    check("R7", 64'(bc), 64'd33);
    run32(3'd0, 32'h80000000, 32'h80000000, bc); read32("R1");
    run32(3'd0, 32'hFFFFFFF9, 32'd3, bc);        read32("R1");
    // R2 unsigned multiply
    run32(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, bc); read32("R2");
    run32(3'd1, 32'h12345678, 32'h9ABCDEF0, bc); read32("R2");
    // R4 signed divide
    run32(3'd2, 32'hFFFFFFF9, 32'd2, bc);        read32("R4");
    check("R7", 64'(bc), 64'd33);
    run32(3'd2, 32'd7, 32'hFFFFFFFE, bc);        read32("R4");
    run32(3'd2, 32'h80000000, 32'hFFFFFFFF, bc); read32("R4");
    check("R4", {expHi, expLo}, {32'd0, 32'h80000000});
    // R3 unsigned divide
    run32(3'd3, 32'hFFFFFFFF, 32'h10, bc);       read32("R3");
    run32(3'd3, 32'd5, 32'd9, bc);               read32("R3");
    // R5 divide by zero
    run32(3'd2, 32'h1234, 32'd0, bc); read32("R5"); check("R5", 64'(bc), 64'd0);
    run32(3'd3, 32'h1234, 32'd0, bc); read32("R5"); check("R5", 64'(bc), 64'd0);
    // R6 moves
    run32(3'd4, 32'hCAFEF00D, 32'd0, bc); read32("R6"); check("R6", 64'(bc), 64'd0);
    run32(3'd5, 32'h0BADBEEF, 32'd0, bc); read32("R6");
    // R12 unused codes
    run32(3'd6, 32'h11111111, 32'h2, bc); read32("R12"); check("R12", 64'(bc), 64'd0);
    run32(3'd7, 32'h22222222, 32'h3, bc); read32("R12");

    // R8 R9 R10 behaviour during a run
    @(negedge clk);
    vB = 1; opB_ = 3'd1; aB = 32'd1000; bB = 32'd1000;
    @(posedge clk);
    @(negedge clk);
    vB = 1; opB_ = 3'd4; aB = 32'h5A5A5A5A;   // must be refused
    rqB = 1; slB = 0; #1;
    check("R10", {63'd0, stB}, 64'd1);
    check("R9", {63'd0, rdyB}, 64'd0);
    check("R8", {32'd0, dB}, {32'd0, expLo});
    repeat (5) @(negedge clk);
    slB = 1; #1;
    check("R8", {32'd0, dB}, {32'd0, expHi});
    vB = 0;
    while (bzB) @(negedge clk);
    #1;
    check("R10", {63'd0, stB}, 64'd0);
    model32(3'd1, 32'd1000, 32'd1000);
    rqB = 0;
    read32("R9");

    // exhaustive sweep on the small instance
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          runSmall(3'(op), SW'(a), SW'(b));
          slS = 1; #1;
          check(b == 0 && op >= 2 ? "R5" :
                op == 0 ? "R1" : op == 1 ? "R2" : op == 2 ? "R4" : "R3",
                {60'd0, dS}, {60'd0, expHiS});
          slS = 0; #1;
          check(b == 0 && op >= 2 ? "R5" :
                op == 0 ? "R1" : op == 1 ? "R2" : op == 2 ? "R4" : "R3",
                {60'd0, dS}, {60'd0, expLoS});
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule